// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block is a byte-wide static RAM in which every word has a nonvolatile shadow word next to it. The host sees a conventional SRAM port that is sampled on a system clock, with active-low chip, output and write enables. Most of the time the block acts as a plain read/write memory. When a transfer is requested, it stops serving the port and walks the whole array one word per clock. A STORE copies the working words into the shadow. A RECALL first zeroes every working word and then copies the shadow back. The shadow is never written during a RECALL.

Transfers have four sources. A falling power-good signal requests a STORE and a rising one requests a RECALL. Pulling the open-drain store/busy line low requests a STORE. Software can request either transfer by issuing six consecutive reads to fixed keyed addresses; the sixth address chooses which transfer runs. Any other access in the middle of the keyed sequence cancels it. While a transfer runs, the block holds the store/busy line low. When the block returns to memory mode, it raises a done flag for one cycle. Two transfers never overlap. The one exception is a power loss during a RECALL: that STORE is remembered and runs straight after the RECALL.

Top module: `nvram_xfer_ctrl`

## Requirements
- R1: While rst_n is low: sb_pull_en, rdata_en and xfer_done are 0. sb_out_lvl is always 0.
- R2: In memory mode, a cycle with cen_n=0 and wen_n=0 writes wdata to addr. A cycle with cen_n=0 and wen_n=1 reads addr. In the following cycle rdata holds the byte, and rdata_en is 1 only if oen_n was 0.
- R3: A rising edge on pwr_good (including pwr_good already high when reset ends) starts a RECALL. A RECALL keeps the block busy for 2*DEPTH cycles, DEPTH = 2**ADDR_W.
- R4: Six consecutive reads to 0x0E, 0xB1, 0x4D, 0x72, 0xE9 and then 0x3C start a STORE in the next cycle. A STORE keeps the block busy for DEPTH cycles.
- R5: The same five leading reads followed by a read of 0xC3 start a RECALL. After the RECALL, every word reads back the value it held at the last STORE.
- R6: A write, or a read of a non-matching address, in the middle of a keyed sequence cancels it, and no transfer starts. A new full sequence afterwards works as normal.
- R7: A falling edge on sb_line_in while in memory mode starts a STORE. sb_pull_en is 1 for exactly the cycles of any transfer.
- R8: While busy, writes are discarded, rdata_en stays 0, and keyed reads do not advance the sequence.
- R9: A RECALL zeroes the working array and then copies the shadow into it. It never modifies the shadow, so two RECALLs in a row give the same contents.
- R10: A falling edge on pwr_good in memory mode starts a STORE of the current contents.
- R11: A STORE and a RECALL never overlap, and a trigger that arrives while busy is dropped. The exception is a pwr_good fall during a RECALL, including its final cycle: a STORE then follows with no idle cycle, for 3*DEPTH busy cycles in total.
- R12: xfer_done is a single-cycle pulse in the first memory-mode cycle after a transfer chain, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; edges request transfers |
| cen_n | input | 1 | Chip enable, active low |
| oen_n | input | 1 | Output enable, active low |
| wen_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rdata_en | output | 1 | Read data driven (output enable) |
| sb_line_in | input | 1 | Sensed level of the store/busy line |
| sb_pull_en | output | 1 | Enable for pulling the store/busy line |
| sb_out_lvl | output | 1 | Level driven when enabled (always 0) |
| xfer_done | output | 1 | One-cycle transfer completion pulse |

## Verification
The collision that matters is a power-good fall arriving while the engine is closing a RECALL. In the very cycle that the last word is copied, the engine must choose between going idle and starting the queued STORE.

The bench provokes this in two ways:
- It drops pwr_good partway through a RECALL.
- It drops pwr_good exactly at the final copy cycle, counted from the first busy cycle.

In both cases it checks that the busy window is 3*DEPTH cycles without a gap and that exactly one done pulse appears, after the STORE.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_STORE = 2'd1,
      XF_CLEAR = 2'd2,
      XF_COPY  = 2'd3
   } xf_state_e;

   localparam int unsigned NUM_KEYS = 5;

endpackage

// File: rtl/nvx_key_seq.sv
module nvx_key_seq
   import nvx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned K0          = 'h0E,
   parameter int unsigned K1          = 'hB1,
   parameter int unsigned K2          = 'h4D,
   parameter int unsigned K3          = 'h72,
   parameter int unsigned K4          = 'hE9,
   parameter int unsigned STORE_TAIL  = 'h3C,
   parameter int unsigned RECALL_TAIL = 'hC3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic              hold,
   input  logic [ADDR_W-1:0] addr,
   output logic              sw_store,
   output logic              sw_recall,
   output logic [2:0]        step
);

   localparam logic [NUM_KEYS-1:0][ADDR_W-1:0] KEYS = {
      ADDR_W'(K4), ADDR_W'(K3), ADDR_W'(K2), ADDR_W'(K1), ADDR_W'(K0)
   };

   if (STORE_TAIL == RECALL_TAIL) begin : g_bad_tail
      $error("store and recall tail addresses must differ");
   end

   logic [NUM_KEYS-1:0] hit;
   logic [2:0]          step_q, step_d;
   logic                step_hit, at_tail, is_st, is_rc;

   for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_hit
      assign hit[gi] = (addr == KEYS[gi]);
   end

   always_comb begin
      step_hit = 1'b0;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (step_q == 3'(i)) step_hit = hit[i];
      end
   end

   assign at_tail   = (step_q == 3'(NUM_KEYS));
   assign is_st     = (addr == ADDR_W'(STORE_TAIL));
   assign is_rc     = (addr == ADDR_W'(RECALL_TAIL));
   assign sw_store  = acc_rd & ~hold & at_tail & is_st;
   assign sw_recall = acc_rd & ~hold & at_tail & is_rc;

   always_comb begin
      step_d = step_q;
      if (hold || acc_wr) begin
         step_d = 3'd0;
      end else if (acc_rd) begin
         if (!at_tail && step_hit)      step_d = step_q + 3'd1;
         else if (at_tail && (is_st || is_rc)) step_d = 3'd0;
         else                           step_d = hit[0] ? 3'd1 : 3'd0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= 3'd0;
      else        step_q <= step_d;
   end

   assign step = step_q;

endmodule

// File: rtl/nvx_xfer_fsm.sv
module nvx_xfer_fsm
   import nvx_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_store,
   input  logic              req_recall,
   input  logic              pd_evt,
   output xf_state_e         state,
   output logic [ADDR_W-1:0] cnt,
   output logic              done
);

   localparam logic [ADDR_W-1:0] LAST = '1;

   xf_state_e state_q;
   logic      pend_q;
   logic      at_last;

   assign at_last = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XF_IDLE;
         cnt     <= '0;
         pend_q  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            XF_IDLE: begin
               cnt    <= '0;
               pend_q <= 1'b0;
               if (req_store)       state_q <= XF_STORE;
               else if (req_recall) state_q <= XF_CLEAR;
            end
            XF_STORE: begin
               cnt <= cnt + 1'b1;
               if (at_last) begin
                  state_q <= XF_IDLE;
                  done    <= 1'b1;
               end
            end
            XF_CLEAR: begin
               cnt <= cnt + 1'b1;
               if (pd_evt)  pend_q  <= 1'b1;
               if (at_last) state_q <= XF_COPY;
            end
            XF_COPY: begin
               cnt <= cnt + 1'b1;
               if (pd_evt) pend_q <= 1'b1;
               if (at_last) begin
                  if (pend_q || pd_evt) begin
                     state_q <= XF_STORE;
                     pend_q  <= 1'b0;
                  end else begin
                     state_q <= XF_IDLE;
                     done    <= 1'b1;
                  end
               end
            end
            default: state_q <= XF_IDLE;
         endcase
      end
   end

   assign state = state_q;

endmodule

// File: rtl/nvx_twin_array.sv
module nvx_twin_array #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              w_we,
   input  logic [ADDR_W-1:0] w_addr,
   input  logic [DATA_W-1:0] w_din,
   output logic [DATA_W-1:0] w_dout,
   input  logic              s_we,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_din,
   output logic [DATA_W-1:0] s_dout
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] work_mem   [DEPTH];
   logic [DATA_W-1:0] shadow_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (w_we) work_mem[w_addr] <= w_din;
   end

   always_ff @(posedge clk) begin
      if (s_we) shadow_mem[s_addr] <= s_din;
   end

   assign w_dout = work_mem[w_addr];
   assign s_dout = shadow_mem[s_addr];

endmodule

// File: rtl/nvram_xfer_ctrl.sv
module nvram_xfer_ctrl
   import nvx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned K0          = 'h0E,
   parameter int unsigned K1          = 'hB1,
   parameter int unsigned K2          = 'h4D,
   parameter int unsigned K3          = 'h72,
   parameter int unsigned K4          = 'hE9,
   parameter int unsigned STORE_TAIL  = 'h3C,
   parameter int unsigned RECALL_TAIL = 'hC3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              cen_n,
   input  logic              oen_n,
   input  logic              wen_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_en,
   input  logic              sb_line_in,
   output logic              sb_pull_en,
   output logic              sb_out_lvl,
   output logic              xfer_done
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (ADDR_W < 4 || ADDR_W > 15) begin : g_bad_aw
      $error("ADDR_W must be in 4..15");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be at least 1");
   end
   if (K0 >= DEPTH || K1 >= DEPTH || K2 >= DEPTH || K3 >= DEPTH || K4 >= DEPTH
       || STORE_TAIL >= DEPTH || RECALL_TAIL >= DEPTH) begin : g_bad_key
      $error("keyed addresses must lie inside the array");
   end

   xf_state_e         xf_state;
   logic [ADDR_W-1:0] xf_cnt;
   logic              xf_idle, acc_rd, acc_wr, port_we;
   logic              pwr_q, sb_q, pd_evt, pu_evt, sb_fall;
   logic              sw_store, sw_recall;
   logic [2:0]        seq_step;
   logic              work_we, shadow_we;
   logic [ADDR_W-1:0] work_addr;
   logic [DATA_W-1:0] work_din, work_dout, shadow_dout;
   logic [DATA_W-1:0] rdata_q;
   logic              rd_en_q;

   assign xf_idle = (xf_state == XF_IDLE);
   assign acc_rd  = ~cen_n & wen_n;
   assign acc_wr  = ~cen_n & ~wen_n;
   assign port_we = acc_wr & xf_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q <= 1'b0;
         sb_q  <= 1'b1;
      end else begin
         pwr_q <= pwr_good;
         sb_q  <= sb_line_in;
      end
   end

   assign pd_evt  = pwr_q & ~pwr_good;
   assign pu_evt  = ~pwr_q & pwr_good;
   assign sb_fall = sb_q & ~sb_line_in;

   nvx_key_seq #(
      .ADDR_W(ADDR_W), .K0(K0), .K1(K1), .K2(K2), .K3(K3), .K4(K4),
      .STORE_TAIL(STORE_TAIL), .RECALL_TAIL(RECALL_TAIL)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_rd   (acc_rd),
      .acc_wr   (acc_wr),
      .hold     (~xf_idle),
      .addr     (addr),
      .sw_store (sw_store),
      .sw_recall(sw_recall),
      .step     (seq_step)
   );

   nvx_xfer_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_store (pd_evt | sb_fall | sw_store),
      .req_recall(pu_evt | sw_recall),
      .pd_evt    (pd_evt),
      .state     (xf_state),
      .cnt       (xf_cnt),
      .done      (xfer_done)
   );

   assign work_we   = port_we | (xf_state == XF_CLEAR) | (xf_state == XF_COPY);
   assign work_addr = xf_idle ? addr : xf_cnt;
   assign shadow_we = (xf_state == XF_STORE);

   always_comb begin
      unique case (xf_state)
         XF_COPY:  work_din = shadow_dout;
         XF_CLEAR: work_din = '0;
         default:  work_din = wdata;
      endcase
   end

   nvx_twin_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .w_we  (work_we),
      .w_addr(work_addr),
      .w_din (work_din),
      .w_dout(work_dout),
      .s_we  (shadow_we),
      .s_addr(xf_cnt),
      .s_din (work_dout),
      .s_dout(shadow_dout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rd_en_q <= 1'b0;
      end else begin
         rd_en_q <= acc_rd & xf_idle & ~oen_n;
         if (acc_rd && xf_idle) rdata_q <= work_dout;
      end
   end

   assign rdata      = rdata_q;
   assign rdata_en   = rd_en_q;
   assign sb_pull_en = ~xf_idle;
   assign sb_out_lvl = 1'b0;

endmodule

// File: rtl/nvx_ctrl_chk.sv
module nvx_ctrl_chk
   import nvx_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      sb_pull_en,
   input logic      rdata_en,
   input logic      xfer_done,
   input logic      cen_n,
   input logic      wen_n,
   input logic      port_we,
   input logic      shadow_we,
   input xf_state_e state,
   input logic [2:0] seq_step
);

   // R8
   busy_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_pull_en && $past(sb_pull_en)) |-> !rdata_en);

   // R8
   busy_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != XF_IDLE) |-> !port_we);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (!sb_pull_en && $past(sb_pull_en)));

   // R9
   recall_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == XF_CLEAR || state == XF_COPY) |-> !shadow_we);

   // R6
   seq_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && !wen_n) |=> (seq_step == 3'd0));

endmodule

bind nvram_xfer_ctrl nvx_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sb_pull_en(sb_pull_en),
   .rdata_en  (rdata_en),
   .xfer_done (xfer_done),
   .cen_n     (cen_n),
   .wen_n     (wen_n),
   .port_we   (port_we),
   .shadow_we (shadow_we),
   .state     (xf_state),
   .seq_step  (seq_step)
);

// File: tb/nvram_xfer_ctrl_tb.sv
module nvram_xfer_ctrl_tb;

   localparam int D      = 256;
   localparam int KA0    = 'h0E;
   localparam int KA1    = 'hB1;
   localparam int KA2    = 'h4D;
   localparam int KA3    = 'h72;
   localparam int KA4    = 'hE9;
   localparam int ST_T   = 'h3C;
   localparam int RC_T   = 'hC3;

   logic       clk = 1'b0;
   logic       rst_n, pwr_good, cen_n, oen_n, wen_n, ext_pull;
   logic [7:0] addr, wdata, rdata;
   logic       rdata_en, sb_line, sb_pull_en, sb_out_lvl, xfer_done;
   int         vec = 0, bad = 0, busy_cnt = 0, done_cnt = 0;

   always #5 clk = ~clk;

   assign sb_line = (ext_pull || sb_pull_en) ? 1'b0 : 1'b1;

   nvram_xfer_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cen_n(cen_n),
      .oen_n(oen_n), .wen_n(wen_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_en(rdata_en), .sb_line_in(sb_line),
      .sb_pull_en(sb_pull_en), .sb_out_lvl(sb_out_lvl), .xfer_done(xfer_done)
   );

   always @(posedge clk) begin
      if (sb_pull_en) busy_cnt = busy_cnt + 1;
      if (xfer_done)  done_cnt = done_cnt + 1;
   end

   function automatic logic [7:0] pat(input int a, input int s);
      return 8'((a * s + s * 3 + 1) & 255);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic acc(input int a, input bit wr, input int d, input bit oe_n);
      addr = 8'(a); wdata = 8'(d); cen_n = 1'b0; wen_n = !wr; oen_n = oe_n;
      @(negedge clk);
      cen_n = 1'b1; wen_n = 1'b1; oen_n = 1'b1;
   endtask

   task automatic rd_chk(input int a, input int exp, input string req);
      acc(a, 1'b0, 0, 1'b0);
      check(rdata_en === 1'b1 && rdata === 8'(exp), req, int'(rdata), exp);
   endtask

   task automatic fill(input int s);
      for (int a = 0; a < D; a++) acc(a, 1'b1, int'(pat(a, s)), 1'b1);
   endtask

   task automatic key_seq(input int tail);
      acc(KA0, 1'b0, 0, 1'b1); acc(KA1, 1'b0, 0, 1'b1); acc(KA2, 1'b0, 0, 1'b1);
      acc(KA3, 1'b0, 0, 1'b1); acc(KA4, 1'b0, 0, 1'b1); acc(tail, 1'b0, 0, 1'b1);
   endtask

   task automatic wait_done(input int exp_len, input string req);
      while (sb_pull_en) @(negedge clk);
      check(busy_cnt == exp_len, req, busy_cnt, exp_len);
      check(xfer_done === 1'b1, "R12", int'(xfer_done), 1);
      @(negedge clk);
      check(xfer_done === 1'b0, "R12", int'(xfer_done), 0);
   endtask

   task automatic t_reset;
      check(sb_pull_en === 1'b0, "R1", int'(sb_pull_en), 0);
      check(rdata_en === 1'b0, "R1", int'(rdata_en), 0);
      check(xfer_done === 1'b0, "R1", int'(xfer_done), 0);
      check(sb_out_lvl === 1'b0, "R1", int'(sb_out_lvl), 0);
      busy_cnt = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_powerup;
      check(sb_pull_en === 1'b1, "R3 start", int'(sb_pull_en), 1);
      wait_done(2 * D, "R3");
   endtask

   task automatic t_rw;
      for (int i = 0; i < 12; i++) acc(i * 21, 1'b1, int'(pat(i, 11)), 1'b1);
      for (int i = 0; i < 12; i++) rd_chk(i * 21, int'(pat(i, 11)), "R2");
      acc(21, 1'b0, 0, 1'b1);
      check(rdata_en === 1'b0, "R2 oen", int'(rdata_en), 0);
   endtask

   task automatic t_sw;
      fill(3);
      busy_cnt = 0;
      key_seq(ST_T);
      check(sb_pull_en === 1'b1, "R4 start", int'(sb_pull_en), 1);
      wait_done(D, "R4");
      fill(5);
      rd_chk(77, int'(pat(77, 5)), "R2");
      busy_cnt = 0;
      key_seq(RC_T);
      check(sb_pull_en === 1'b1, "R5 start", int'(sb_pull_en), 1);
      wait_done(2 * D, "R9");
      rd_chk(0, int'(pat(0, 3)), "R5");
      rd_chk(77, int'(pat(77, 3)), "R5");
      rd_chk(255, int'(pat(255, 3)), "R5");
      acc(77, 1'b1, 0, 1'b1);
      busy_cnt = 0;
      key_seq(RC_T);
      wait_done(2 * D, "R9");
      rd_chk(77, int'(pat(77, 3)), "R9");
      rd_chk(1, int'(pat(1, 3)), "R9");
   endtask

   task automatic t_abort;
      acc(KA0, 1'b0, 0, 1'b1); acc(KA1, 1'b0, 0, 1'b1); acc(KA2, 1'b0, 0, 1'b1);
      acc('h10, 1'b1, 'h99, 1'b1);
      acc(KA3, 1'b0, 0, 1'b1); acc(KA4, 1'b0, 0, 1'b1); acc(ST_T, 1'b0, 0, 1'b1);
      check(sb_pull_en === 1'b0, "R6 write abort", int'(sb_pull_en), 0);
      acc(KA0, 1'b0, 0, 1'b1); acc(KA1, 1'b0, 0, 1'b1); acc(KA2, 1'b0, 0, 1'b1);
      acc(KA3, 1'b0, 0, 1'b1); acc('h55, 1'b0, 0, 1'b1);
      acc(KA4, 1'b0, 0, 1'b1); acc(RC_T, 1'b0, 0, 1'b1);
      check(sb_pull_en === 1'b0, "R6 read abort", int'(sb_pull_en), 0);
      repeat (3) @(negedge clk);
      check(sb_pull_en === 1'b0, "R6 idle", int'(sb_pull_en), 0);
      busy_cnt = 0;
      key_seq(ST_T);
      check(sb_pull_en === 1'b1, "R6 restart", int'(sb_pull_en), 1);
      wait_done(D, "R6");
   endtask

   task automatic t_pin_busy;
      acc('h20, 1'b1, 'h5A, 1'b1);
      busy_cnt = 0;
      ext_pull = 1'b1;
      @(negedge clk);
      check(sb_pull_en === 1'b1, "R7", int'(sb_pull_en), 1);
      check(sb_out_lvl === 1'b0, "R7 level", int'(sb_out_lvl), 0);
      @(negedge clk);
      ext_pull = 1'b0;
      acc('h20, 1'b1, 'hA5, 1'b1);
      acc('h20, 1'b0, 0, 1'b0);
      check(rdata_en === 1'b0, "R8 rd", int'(rdata_en), 0);
      key_seq(RC_T);
      wait_done(D, "R11");
      rd_chk('h20, 'h5A, "R8 wr");
      acc(RC_T, 1'b0, 0, 1'b1);
      check(sb_pull_en === 1'b0, "R8 seq", int'(sb_pull_en), 0);
   endtask

   task automatic t_power;
      fill(7);
      busy_cnt = 0;
      pwr_good = 1'b0;
      @(negedge clk);
      check(sb_pull_en === 1'b1, "R10 start", int'(sb_pull_en), 1);
      wait_done(D, "R10");
      for (int a = 0; a < 8; a++) acc(a, 1'b1, int'(pat(a, 9)), 1'b1);
      busy_cnt = 0;
      pwr_good = 1'b1;
      @(negedge clk);
      wait_done(2 * D, "R3");
      for (int a = 0; a < 8; a++) rd_chk(a, int'(pat(a, 7)), "R10");
   endtask

   task automatic t_queue(input int lag, input string req);
      busy_cnt = 0;
      done_cnt = 0;
      key_seq(RC_T);
      repeat (lag) @(negedge clk);
      pwr_good = 1'b0;
      wait_done(3 * D, req);
      check(done_cnt == 1, "R12 once", done_cnt, 1);
      busy_cnt = 0;
      pwr_good = 1'b1;
      @(negedge clk);
      wait_done(2 * D, "R3");
      rd_chk(5, int'(pat(5, 7)), req);
   endtask

   initial begin
      rst_n = 1'b0; pwr_good = 1'b1; cen_n = 1'b1; wen_n = 1'b1; oen_n = 1'b1;
      addr = '0; wdata = '0; ext_pull = 1'b0;
      repeat (3) @(negedge clk);
      t_reset;
      t_powerup;
      t_rw;
      t_sw;
      t_abort;
      t_pin_busy;
      t_power;
      t_queue(20, "R11 mid");
      t_queue(2 * D - 1, "R11 last");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      vec++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule